// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Size Probe

This block fetches 16-bit words from a serial configuration EEPROM over a four-wire link: chip select, serial clock, serial data toward the part and serial data back from it. The part may hold 64 or 256 words. The block is not told which. Straight after reset it runs one probe access that finds the address width on the wire. It sends the read code, then shifts address zeros one bit at a time. After each bit it looks at the returned line. The part pulls that line low once it has taken its last address bit, so the number of bits sent at that moment is the address width.

Once the probe is done, the host asks for words over a plain port: a request strobe with an address, a busy flag, and a one-cycle valid strobe with the data. Every serial clock period holds the clock high and low for at least a set number of system clock cycles, and both minimums are parameters. A part that never answers, or that answers at an unexpected bit count, raises a size-error flag and the block falls back to the 64-word width.

Top module: `eeprom_word_reader`

## Requirements
- R1: While reset is low, chip select is low, valid is low and busy is high. After reset the block runs the size probe without being asked. Busy stays high until the probe has finished, and chip select and serial clock stay low whenever busy is low.
- R2: If the returned line first reads 0 after the 8th address bit of the probe, the address-width output becomes 8 and size error stays 0.
- R3: If the returned line first reads 0 after the 6th address bit of the probe, the address-width output becomes 6 and size error stays 0.
- R4: If the line reads 0 at any other bit count, or stays 1 through 8 address bits, size error becomes 1 and the width becomes 6. The probe access ends at that bit. A later read then returns whatever the line carries (16'hFFFF from a silent part).
- R5: Each access raises chip select and then sends the code 1,1,0 (start bit first). The probe follows this with all-zero address bits. A read follows it with exactly width address bits, most significant first, taken from the low bits of the request address, and then gives 16 more serial clocks. Chip select then drops.
- R6: The serial clock stays high for at least T_HIGH and low for at least T_LOW system cycles, including the first low time after chip select rises. The outgoing data bit changes only while the serial clock is low.
- R7: Between two accesses, chip select stays low for at least T_LOW system cycles.
- R8: The returned word is made of the 16 bits that follow the dummy zero, first bit as bit 15.
- R9: Valid is high for exactly one cycle per read. It rises (3 + width + 16) x (T_HIGH + T_LOW) + T_LOW cycles after the clock edge that accepted the request, and busy is low in the cycle after it.
- R10: A request is taken only while busy is low. A request or address change during a transfer has no effect on that transfer and starts no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Read request, sampled while busy is low |
| addr_i | input | LARGE_AW | Word address; only the low width bits are sent |
| busy_o | output | 1 | High during the probe, any access and the gap after it |
| valid_o | output | 1 | One-cycle strobe marking data_o |
| data_o | output | DW | Last word read |
| addr_bits_o | output | $clog2(LARGE_AW+1) | Address width found by the probe |
| size_err_o | output | 1 | Probe did not find a legal width |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The behavioural part model in the bench is reset four times, each time acting as a different device. As a 256-word part it separates the width-8 path from the width-6 path. As a 64-word part it shows that the upper address bits are dropped. As a 7-bit part it covers the case of a zero at an illegal count. As a silent part it covers a zero that never appears. In each legal setting, seeded random addresses are mixed with the all-zero and all-one addresses, so that a swapped or misaligned address bit shows as a wrong word or a wrong address seen by the model. One read per setting toggles request and address during the transfer, which separates a block that ignores them from one that restarts or queues another access. The exact valid latency catches an extra or missing bit period, and a monitor measures every clock phase, every chip-select gap and every data change on the wire.

// File: rtl/ee_pkg.sv
// Shared types and constants for the serial EEPROM word reader.
// Assumes a three-bit read code: start bit then two opcode bits.
package ee_pkg;
    typedef enum logic [1:0] {
        ST_PROBE = 2'd0,
        ST_XFER  = 2'd1,
        ST_GAP   = 2'd2,
        ST_IDLE  = 2'd3
    } seq_state_t;

    localparam int         CODE_BITS = 3;
    localparam logic [2:0] READ_CODE = 3'b110;
endpackage

// File: rtl/ee_sk_timer.sv
// Serial clock generator. While run_i is high it repeats one bit period:
// T_LOW cycles low, then T_HIGH cycles high. tick_o marks the last high
// cycle, the moment to sample the returned bit and advance the outgoing bit.
// Assumes T_HIGH and T_LOW are at least 1. Idles low when run_i is low.
module ee_sk_timer #(
    parameter int T_HIGH = 2,
    parameter int T_LOW  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sk_o,
    output logic tick_o
);
    localparam int TMAX = (T_HIGH > T_LOW) ? T_HIGH : T_LOW;
    localparam int CW   = $clog2(TMAX + 1);

    logic          hi_q;
    logic [CW-1:0] cnt_q;

    // Phase and dwell counter for the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            hi_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!hi_q) begin
            if (cnt_q == CW'(T_LOW - 1)) begin
                hi_q  <= 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == CW'(T_HIGH - 1)) begin
                hi_q  <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sk_o   = hi_q;
    assign tick_o = run_i && hi_q && (cnt_q == CW'(T_HIGH - 1));
endmodule

// File: rtl/ee_shift_unit.sv
// Serial shifters. The output register is loaded with code and address
// and sends its MSB first; zeros follow once it is empty. The input
// register gathers returned bits MSB first into a word.
module ee_shift_unit #(
    parameter int OW = 11,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [OW-1:0] load_val_i,
    input  logic          shift_i,
    output logic          di_o,
    input  logic          cap_i,
    input  logic          do_i,
    output logic [IW-1:0] word_o
);
    logic [OW-1:0] osr_q;
    logic [IW-1:0] isr_q;

    // Outgoing bit register: load on a new access, advance at each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n)       osr_q <= '0;
        else if (load_i)  osr_q <= load_val_i;
        else if (shift_i) osr_q <= {osr_q[OW-2:0], 1'b0};
    end

    // Incoming word register: take one returned bit per data period.
    always_ff @(posedge clk) begin
        if (!rst_n)     isr_q <= '0;
        else if (cap_i) isr_q <= {isr_q[IW-2:0], do_i};
    end

    assign di_o   = osr_q[OW-1];
    assign word_o = isr_q;
endmodule

// File: rtl/ee_size_judge.sv
// Decides the probe outcome from the number of address bits sent so far
// and the returned bit. A zero at SMALL_AW or LARGE_AW gives that width.
// A zero at any other count, or no zero by LARGE_AW, is an error that
// falls back to SMALL_AW.
module ee_size_judge #(
    parameter int SMALL_AW = 6,
    parameter int LARGE_AW = 8,
    parameter int CNTW     = 5,
    parameter int WW       = 4
) (
    input  logic [CNTW-1:0] count_i,
    input  logic            do_i,
    output logic            stop_o,
    output logic [WW-1:0]   width_o,
    output logic            err_o
);
    // Combinational verdict for the current address bit count.
    always_comb begin
        stop_o  = !do_i || (count_i == CNTW'(LARGE_AW));
        width_o = WW'(SMALL_AW);
        err_o   = 1'b1;
        if (!do_i && count_i == CNTW'(SMALL_AW)) begin
            err_o = 1'b0;
        end else if (!do_i && count_i == CNTW'(LARGE_AW)) begin
            width_o = WW'(LARGE_AW);
            err_o   = 1'b0;
        end
    end
endmodule

// File: rtl/eeprom_word_reader.sv
// Top of the serial EEPROM word reader. Runs a width probe after reset,
// then serves one word read per accepted request. Assumes the part drives
// its data line low once the last address bit has been taken, and
// presents each data bit after a rising serial clock edge.
module eeprom_word_reader
    import ee_pkg::*;
#(
    parameter int T_HIGH   = 2,
    parameter int T_LOW    = 3,
    parameter int SMALL_AW = 6,
    parameter int LARGE_AW = 8,
    parameter int DW       = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_i,
    input  logic [LARGE_AW-1:0]               addr_i,
    output logic                              busy_o,
    output logic                              valid_o,
    output logic [DW-1:0]                     data_o,
    output logic [$clog2(LARGE_AW+1)-1:0]     addr_bits_o,
    output logic                              size_err_o,
    output logic                              ee_cs_o,
    output logic                              ee_sk_o,
    output logic                              ee_di_o,
    input  logic                              ee_do_i
);
    localparam int WW     = $clog2(LARGE_AW + 1);
    localparam int OW     = CODE_BITS + LARGE_AW;
    localparam int NB_MAX = CODE_BITS + LARGE_AW + DW;
    localparam int BW     = $clog2(NB_MAX + 1);
    localparam int GW     = $clog2(T_LOW + 1);

    seq_state_t        state_q;
    logic              probe_q;
    logic [WW-1:0]     aw_q;
    logic              err_q;
    logic              cs_q;
    logic              valid_q;
    logic [DW-1:0]     data_q;
    logic [BW-1:0]     bitn_q;
    logic [GW-1:0]     gap_q;

    logic              run, tick, sk;
    logic              load, cap, di;
    logic [OW-1:0]     load_val;
    logic [LARGE_AW-1:0] aligned;
    logic [DW-1:0]     word;
    logic [BW-1:0]     bitn_nx, addr_cnt, read_total, data_start;
    logic              j_stop, j_err;
    logic [WW-1:0]     j_width;

    assign run        = (state_q == ST_XFER);
    assign bitn_nx    = bitn_q + 1'b1;
    assign addr_cnt   = bitn_nx - BW'(CODE_BITS);
    assign data_start = BW'(CODE_BITS) + BW'(aw_q);
    assign read_total = data_start + BW'(DW);

    ee_sk_timer #(.T_HIGH(T_HIGH), .T_LOW(T_LOW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run), .sk_o(sk), .tick_o(tick)
    );

    // Left-justify the request address in the width found by the probe.
    always_comb begin
        if (aw_q == WW'(LARGE_AW)) aligned = addr_i;
        else                       aligned = addr_i << (LARGE_AW - SMALL_AW);
        load_val = (state_q == ST_PROBE) ? {READ_CODE, {LARGE_AW{1'b0}}}
                                         : {READ_CODE, aligned};
    end

    assign load = (state_q == ST_PROBE) || (state_q == ST_IDLE && req_i);
    assign cap  = tick && !probe_q && (bitn_q >= data_start);

    ee_shift_unit #(.OW(OW), .IW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
        .shift_i(tick), .di_o(di), .cap_i(cap), .do_i(ee_do_i), .word_o(word)
    );

    ee_size_judge #(.SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW), .CNTW(BW), .WW(WW)) u_judge (
        .count_i(addr_cnt), .do_i(ee_do_i),
        .stop_o(j_stop), .width_o(j_width), .err_o(j_err)
    );

    // Access sequencer: probe, transfers, chip-select gap and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PROBE;
            probe_q <= 1'b1;
            aw_q    <= WW'(SMALL_AW);
            err_q   <= 1'b0;
            cs_q    <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
            bitn_q  <= '0;
            gap_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_PROBE: begin
                    cs_q    <= 1'b1;
                    probe_q <= 1'b1;
                    bitn_q  <= '0;
                    state_q <= ST_XFER;
                end
                ST_IDLE: begin
                    if (req_i) begin
                        cs_q    <= 1'b1;
                        probe_q <= 1'b0;
                        bitn_q  <= '0;
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        bitn_q <= bitn_nx;
                        if (probe_q && bitn_nx > BW'(CODE_BITS) && j_stop) begin
                            aw_q    <= j_width;
                            err_q   <= j_err;
                            cs_q    <= 1'b0;
                            gap_q   <= '0;
                            state_q <= ST_GAP;
                        end else if (!probe_q && bitn_nx == read_total) begin
                            cs_q    <= 1'b0;
                            gap_q   <= '0;
                            state_q <= ST_GAP;
                        end
                    end
                end
                default: begin
                    if (gap_q == GW'(T_LOW - 1)) begin
                        state_q <= ST_IDLE;
                        if (!probe_q) begin
                            valid_q <= 1'b1;
                            data_q  <= word;
                        end
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign valid_o     = valid_q;
    assign data_o      = data_q;
    assign addr_bits_o = aw_q;
    assign size_err_o  = err_q;
    assign ee_cs_o     = cs_q;
    assign ee_sk_o     = sk;
    assign ee_di_o     = di;

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cs_q && !sk));

    // R6
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sk && $past(sk)) |-> $stable(di));

    // R7
    cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_q) |-> !sk);

    // R4
    err_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (aw_q == WW'(SMALL_AW)));

    // R2
    width_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (aw_q == WW'(SMALL_AW) || aw_q == WW'(LARGE_AW)));
endmodule

// File: tb/sim_eeprom_word_reader.sv
// Bench: behavioural EEPROM model with selectable address width, wire
// timing monitor, seeded random plus directed reads.
module sim_eeprom_word_reader;
    localparam int TH = 2;
    localparam int TL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        busy, valid, size_err, cs, sk, di;
    logic [15:0] data;
    logic [3:0]  abits;
    logic        m_do = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int model_aw = 8;

    always #10 clk = ~clk;

    eeprom_word_reader #(.T_HIGH(TH), .T_LOW(TL), .SMALL_AW(6), .LARGE_AW(8), .DW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
        .busy_o(busy), .valid_o(valid), .data_o(data),
        .addr_bits_o(abits), .size_err_o(size_err),
        .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(m_do)
    );

    function automatic logic [15:0] wordf(input logic [7:0] a);
        logic [7:0] lo;
        lo = (a * 8'd7) ^ 8'hC9;
        return {a ^ 8'h3C, lo};
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Part model: counts rising clock edges inside each select window.
    int         m_k = 0;
    int         m_acc = 0;
    int         m_last_k = 0;
    logic [2:0] m_op = 3'b000;
    logic [2:0] m_last_op = 3'b000;
    logic [7:0] m_addr = 8'h00;
    logic [7:0] m_last_addr = 8'h00;
    always @(posedge sk or negedge cs) begin
        if (!cs) begin
            if (m_k > 0) begin
                m_acc++;
                m_last_k = m_k;
                m_last_op = m_op;
                m_last_addr = m_addr;
            end
            m_k = 0; m_op = 3'b000; m_addr = 8'h00; m_do = 1'b1;
        end else begin
            m_k = m_k + 1;
            if (m_k <= 3) m_op = {m_op[1:0], di};
            else if (model_aw != 0 && m_k <= 3 + model_aw) m_addr = {m_addr[6:0], di};
            if (model_aw != 0 && m_k == 3 + model_aw) m_do = 1'b0;
            else if (model_aw != 0 && m_k > 3 + model_aw && m_k <= 3 + model_aw + 16)
                m_do = wordf(m_addr)[16 - (m_k - 3 - model_aw)];
            else m_do = 1'b1;
        end
    end

    // Wire timing monitor (R6, R7), sampled on the falling system clock edge.
    int   hi_run = 0, lo_run = 0, gap_run = TL;
    int   sk_viol = 0, di_viol = 0, gap_viol = 0;
    logic p_sk = 1'b0, p_cs = 1'b0, p_di = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_run = 0; lo_run = 0; gap_run = TL;
            p_sk = 1'b0; p_cs = 1'b0; p_di = 1'b0;
        end else begin
            if (cs && !p_cs) begin
                if (gap_run < TL) gap_viol++;
                lo_run = 0;
            end
            if (!cs) gap_run++; else gap_run = 0;
            if (sk && !p_sk) begin
                if (lo_run < TL) sk_viol++;
                hi_run = 0;
            end
            if (!sk && p_sk) begin
                if (hi_run < TH) sk_viol++;
                lo_run = 0;
            end
            if (sk) hi_run++; else lo_run++;
            if (sk && p_sk && di !== p_di) di_viol++;
            if (sk && !cs) sk_viol++;
            p_sk = sk; p_cs = cs; p_di = di;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R1 busy clears", 32'(busy), 32'd0);
    endtask

    task automatic reset_with(input int maw);
        model_aw = maw;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset cs", 32'(cs), 32'd0);
        chk("R1 reset valid", 32'(valid), 32'd0);
        chk("R1 reset busy", 32'(busy), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 probe busy", 32'(busy), 32'd1);
        wait_idle();
    endtask

    task automatic do_read(input logic [7:0] a, input bit poke);
        int n = 0;
        int aw;
        int acc0;
        int lat;
        logic [7:0] ea;
        logic [15:0] exp;
        aw = int'(abits);
        ea = (aw == 6) ? {2'b00, a[5:0]} : a;
        exp = (model_aw == 0) ? 16'hFFFF : wordf(ea);
        lat = (3 + aw + 16) * (TH + TL) + TL;
        @(negedge clk);
        req = 1'b1; addr = a;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (n == 0) begin req = 1'b0; addr = ~a; end
            if (poke && n == 10) req = 1'b1;
            if (poke && n == 40) req = 1'b0;
            if (valid) break;
            n++;
            if (n > 4000) break;
        end
        chk("R9 latency", 32'(n), 32'(lat));
        chk("R8 data", 32'(data), 32'(exp));
        chk("R5 code", 32'(m_last_op), 32'h6);
        chk("R5 clocks", 32'(m_last_k), 32'(3 + aw + 16));
        if (model_aw != 0) chk("R5 address", 32'(m_last_addr), 32'(ea));
        acc0 = m_acc;
        @(negedge clk);
        chk("R9 one pulse", 32'(valid), 32'd0);
        chk("R9 busy low", 32'(busy), 32'd0);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk("R10 no restart cs", 32'(cs), 32'd0);
            chk("R10 no extra access", 32'(m_acc), 32'(acc0));
        end
    endtask

    initial begin
        void'($urandom(32'd2718));

        // R2: 256-word part.
        reset_with(8);
        chk("R2 width", 32'(abits), 32'd8);
        chk("R2 no error", 32'(size_err), 32'd0);
        chk("R5 probe clocks", 32'(m_last_k), 32'd11);
        chk("R5 probe code", 32'(m_last_op), 32'h6);
        chk("R5 probe zeros", 32'(m_last_addr), 32'h0);
        do_read(8'h00, 1'b0);
        do_read(8'hFF, 1'b0);
        do_read(8'h81, 1'b1);
        for (int i = 0; i < 24; i++) do_read(8'($urandom), 1'b0);

        // R3: 64-word part, upper address bits dropped.
        reset_with(6);
        chk("R3 width", 32'(abits), 32'd6);
        chk("R3 no error", 32'(size_err), 32'd0);
        chk("R5 probe clocks", 32'(m_last_k), 32'd9);
        do_read(8'h00, 1'b0);
        do_read(8'hFF, 1'b0);
        do_read(8'hC5, 1'b1);
        for (int i = 0; i < 24; i++) do_read(8'($urandom), 1'b0);

        // R4: zero at an illegal count.
        reset_with(7);
        chk("R4 width odd", 32'(abits), 32'd6);
        chk("R4 error odd", 32'(size_err), 32'd1);
        chk("R4 probe stops", 32'(m_last_k), 32'd10);

        // R4: silent part.
        reset_with(0);
        chk("R4 width none", 32'(abits), 32'd6);
        chk("R4 error none", 32'(size_err), 32'd1);
        chk("R4 probe stops", 32'(m_last_k), 32'd11);
        do_read(8'h2A, 1'b0);

        // R6, R7: wire timing seen by the monitor.
        chk("R6 sk phases", 32'(sk_viol), 32'd0);
        chk("R6 di stable", 32'(di_viol), 32'd0);
        chk("R7 cs gap", 32'(gap_viol), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule